// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block holds the 64-bit base-address register that places the memory-mapped PCIe configuration space in the system address map, and turns it into a live window decode. Software writes the register through a byte-enabled write port. Every write that touches at least one byte re-evaluates the decode. The block then presents the window enable, the window base and the window size, and it flags a hit for any incoming memory address that falls inside an enabled window.

The two-bit length code picks one of three window sizes. It also decides which low base bits count toward the decoded base. The fourth length code is reserved. A write that leaves this code in the register is rejected: the previous window stays in force, and an error pulse is raised. Translating configuration transactions is done downstream and is not part of this block.

Top module: `cfgw_window_dec`

## Requirements
- R1: After reset the window is disabled, the base is 0xB000_0000, the size is 256 MiB (0x1000_0000), len_err_o is low and hit_o is low for any address.
- R2: Register layout: bit 0 is the enable, bits 2:1 are the length code and bits 38:26 hold the base. All other bits are not stored. A write changes only the bytes whose wr_be_i bit is set. Bit n of wr_be_i covers data bits 8n+7:8n.
- R3: Length code 00 selects 256 MiB, 01 selects 128 MiB and 10 selects 64 MiB. size_o gives the window size in bytes.
- R4: The decoded base is the register ANDed with a size-dependent mask. For 256 MiB the mask is bits 38:28. For 128 MiB it is bits 38:26. For 64 MiB it is bits 38:28 plus bit 26, so bit 27 is dropped.
- R5: A write that leaves length code 11 in the register keeps win_en_o, base_o and size_o unchanged. It drives len_err_o high for exactly the cycle after the write.
- R6: The decode is re-evaluated on any accepted write with at least one byte enable set, including writes that touch only bytes holding no field. With wr_en_i low or wr_be_i zero, nothing changes and len_err_o stays low.
- R7: hit_o is high when the window is enabled and (addr_i & ~(size-1)) equals base_o. addr_i is 40 bits wide, so any address bit above bit 38 being set prevents a hit.
- R8: While the window is disabled, hit_o stays low for every address.
- R9: The decode outputs take the new value at the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_be_i | input | 8 | Byte enables of the write |
| wr_data_i | input | 64 | Write data |
| addr_i | input | 40 | Memory address to decode |
| win_en_o | output | 1 | Window active |
| base_o | output | 40 | Decoded window base |
| size_o | output | 40 | Window size in bytes |
| hit_o | output | 1 | addr_i lies in the active window |
| len_err_o | output | 1 | One-cycle pulse after a rejected reserved-length write |

## Verification
A stale register byte or a corrupted decode state shows up on base_o, size_o or win_en_o in the cycle right after the write that should have changed it. The scoreboard compares all four decode outputs one cycle after every write. Wrong masking or a wrong hit comparator shows up immediately as a combinational mismatch on hit_o. The probes sit just inside and just outside each window edge, and they include the case where the 128 MiB base keeps bit 26. After a reserved-code write, any premature update is visible the next cycle. Later writes to unrelated bytes must keep being rejected until the length code is repaired.

// File: rtl/cfgw_pkg.sv
`timescale 1ns/1ps
package cfgw_pkg;
  typedef enum logic [1:0] {
    LEN_256M = 2'b00,
    LEN_128M = 2'b01,
    LEN_64M  = 2'b10,
    LEN_RSVD = 2'b11
  } win_len_e;
endpackage

// File: rtl/cfgw_field_reg.sv
`timescale 1ns/1ps
module cfgw_field_reg #(
  parameter int unsigned REG_W  = 64,
  parameter int unsigned OUT_W  = 40,
  parameter logic [REG_W-1:0] WMASK   = '1,
  parameter logic [REG_W-1:0] RST_VAL = '0,
  localparam int unsigned NBYTES = REG_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [NBYTES-1:0] wr_be_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [OUT_W-1:0]  img_nxt_o,
  output logic              wr_any_o
);
  logic [REG_W-1:0] img_q, img_d, bmask;

  for (genvar b = 0; b < NBYTES; b++) begin : g_bmask
    assign bmask[8*b +: 8] = {8{wr_en_i & wr_be_i[b]}};
  end

  assign wr_any_o  = wr_en_i & (|wr_be_i);
  assign img_d     = ((img_q & ~bmask) | (wr_data_i & bmask)) & WMASK;
  assign img_nxt_o = img_d[OUT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) img_q <= RST_VAL & WMASK;
    else         img_q <= img_d;
  end
endmodule

// File: rtl/cfgw_len_decode.sv
`timescale 1ns/1ps
module cfgw_len_decode
  import cfgw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 40,
  parameter int unsigned BASE_LSB = 26,
  parameter int unsigned BASE_MSB = 38
) (
  input  win_len_e          len_i,
  output logic [ADDR_W-1:0] size_o,
  output logic [ADDR_W-1:0] mask_o,
  output logic              rsvd_o
);
  always_comb begin
    size_o = '0;
    mask_o = '0;
    rsvd_o = 1'b0;
    mask_o[BASE_MSB:BASE_LSB+2] = '1;
    case (len_i)
      LEN_256M: size_o[BASE_LSB+2] = 1'b1;
      LEN_128M: begin
        size_o[BASE_LSB+1] = 1'b1;
        mask_o[BASE_LSB+1] = 1'b1;
        mask_o[BASE_LSB]   = 1'b1;
      end
      LEN_64M: begin
        size_o[BASE_LSB] = 1'b1;
        mask_o[BASE_LSB] = 1'b1;
      end
      default: begin
        rsvd_o = 1'b1;
        mask_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/cfgw_hit.sv
`timescale 1ns/1ps
module cfgw_hit #(
  parameter int unsigned ADDR_W = 40
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] size_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] align_mask;
  assign align_mask = ~(size_i - ADDR_W'(1));
  assign hit_o      = en_i & ((addr_i & align_mask) == base_i);
endmodule

// File: rtl/cfgw_window_dec.sv
`timescale 1ns/1ps
module cfgw_window_dec
  import cfgw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 40,
  parameter int unsigned REG_W    = 64,
  parameter int unsigned EN_BIT   = 0,
  parameter int unsigned LEN_LSB  = 1,
  parameter int unsigned BASE_LSB = 26,
  parameter int unsigned BASE_MSB = 38,
  parameter logic [REG_W-1:0] RST_VAL = 64'h0000_0000_B000_0000,
  localparam int unsigned NBYTES = REG_W / 8,
  localparam int unsigned BASE_W = BASE_MSB - BASE_LSB + 1,
  localparam logic [REG_W-1:0] WMASK =
      (REG_W'(1) << EN_BIT) | (REG_W'(3) << LEN_LSB) |
      (((REG_W'(1) << BASE_W) - REG_W'(1)) << BASE_LSB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [NBYTES-1:0] wr_be_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              win_en_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] size_o,
  output logic              hit_o,
  output logic              len_err_o
);
  logic [ADDR_W-1:0] img_nxt, nxt_size, nxt_mask, rst_size, rst_mask;
  logic              wr_any, nxt_rsvd, rst_rsvd_unused;
  logic              win_en_q, err_q;
  logic [ADDR_W-1:0] base_q, size_q;

  cfgw_field_reg #(
    .REG_W(REG_W), .OUT_W(ADDR_W), .WMASK(WMASK), .RST_VAL(RST_VAL)
  ) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_be_i, .wr_data_i,
    .img_nxt_o(img_nxt),
    .wr_any_o (wr_any)
  );

  cfgw_len_decode #(
    .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .BASE_MSB(BASE_MSB)
  ) u_nxt_dec (
    .len_i (win_len_e'(img_nxt[LEN_LSB+1:LEN_LSB])),
    .size_o(nxt_size),
    .mask_o(nxt_mask),
    .rsvd_o(nxt_rsvd)
  );

  // decode of the reset image supplies the reset window
  cfgw_len_decode #(
    .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .BASE_MSB(BASE_MSB)
  ) u_rst_dec (
    .len_i (win_len_e'(RST_VAL[LEN_LSB+1:LEN_LSB])),
    .size_o(rst_size),
    .mask_o(rst_mask),
    .rsvd_o(rst_rsvd_unused)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_en_q <= RST_VAL[EN_BIT];
      base_q   <= RST_VAL[ADDR_W-1:0] & rst_mask;
      size_q   <= rst_size;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (wr_any) begin
        if (nxt_rsvd) begin
          err_q <= 1'b1;
        end else begin
          win_en_q <= img_nxt[EN_BIT];
          base_q   <= img_nxt & nxt_mask;
          size_q   <= nxt_size;
        end
      end
    end
  end

  cfgw_hit #(.ADDR_W(ADDR_W)) u_hit (
    .en_i  (win_en_q),
    .addr_i(addr_i),
    .base_i(base_q),
    .size_i(size_q),
    .hit_o (hit_o)
  );

  assign win_en_o  = win_en_q;
  assign base_o    = base_q;
  assign size_o    = size_q;
  assign len_err_o = err_q;
endmodule

// File: rtl/cfgw_checker.sv
`timescale 1ns/1ps
module cfgw_checker #(
  parameter int unsigned ADDR_W   = 40,
  parameter int unsigned NBYTES   = 8,
  parameter int unsigned BASE_LSB = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [NBYTES-1:0] wr_be_i,
  input logic [1:0]        wr_len_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              win_en_o,
  input logic [ADDR_W-1:0] base_o,
  input logic [ADDR_W-1:0] size_o,
  input logic              hit_o,
  input logic              len_err_o
);
  assert_hit_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> win_en_o);

  assert_hit_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((addr_i >= base_o) && ((addr_i - base_o) < size_o)));

  assert_size_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(size_o) == 1);

  assert_base_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_o[BASE_LSB-1:0] == '0);

  assert_rsvd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_be_i[0] && wr_len_i == 2'b11) |=>
      ($stable(win_en_o) && $stable(base_o) && $stable(size_o) && len_err_o));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (|wr_be_i)) |=>
      ($stable(win_en_o) && $stable(base_o) && $stable(size_o) && !len_err_o));
endmodule

bind cfgw_window_dec cfgw_checker #(
  .ADDR_W(ADDR_W), .NBYTES(NBYTES), .BASE_LSB(BASE_LSB)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_be_i  (wr_be_i),
  .wr_len_i (wr_data_i[LEN_LSB+1:LEN_LSB]),
  .addr_i   (addr_i),
  .win_en_o (win_en_o),
  .base_o   (base_o),
  .size_o   (size_o),
  .hit_o    (hit_o),
  .len_err_o(len_err_o)
);

// File: tb/test_cfgw_window_dec.sv
`timescale 1ns/1ps
module test_cfgw_window_dec;
  localparam logic [63:0] WM = 64'h0000_007F_FC00_0007;

  typedef struct {
    logic        en;
    logic [39:0] base;
    logic [39:0] size;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_be_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [39:0] addr_i = '0;
  logic        win_en_o, hit_o, len_err_o;
  logic [39:0] base_o, size_o;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  logic [63:0] m_img = 64'h0000_0000_B000_0000;
  logic        d_en = 1'b0;
  logic [39:0] d_base = 40'hB000_0000;
  logic [39:0] d_size = 40'h1000_0000;

  always #2 clk = ~clk;  // 250 MHz

  cfgw_window_dec i_cfgw_window_dec (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_be_i, .wr_data_i, .addr_i,
    .win_en_o, .base_o, .size_o, .hit_o, .len_err_o
  );

  // monitor: compares one expected item per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (win_en_o !== e.en || base_o !== e.base || size_o !== e.size || len_err_o !== e.err) begin
        errors++;
        $display("FAIL %s: act en=%0b base=%h size=%h err=%0b exp en=%0b base=%h size=%h err=%0b",
                 e.tag, win_en_o, base_o, size_o, len_err_o, e.en, e.base, e.size, e.err);
      end
    end
  end

  task automatic wr(input logic wen, input logic [7:0] be, input logic [63:0] data, input string tag);
    exp_t e;
    logic err;
    @(negedge clk);
    wr_en_i = wen; wr_be_i = be; wr_data_i = data;
    @(posedge clk);
    err = 1'b0;
    if (wen && be != 0) begin
      for (int b = 0; b < 8; b++)
        if (be[b]) m_img[8*b +: 8] = data[8*b +: 8];
      m_img = m_img & WM;
      case (m_img[2:1])
        2'b00: begin d_size = 40'h1000_0000; d_base = m_img[39:0] & 40'h7F_F000_0000; end
        2'b01: begin d_size = 40'h0800_0000; d_base = m_img[39:0] & 40'h7F_FC00_0000; end
        2'b10: begin d_size = 40'h0400_0000; d_base = m_img[39:0] & 40'h7F_F400_0000; end
        default: err = 1'b1;
      endcase
      if (!err) d_en = m_img[0];
    end
    e.en = d_en; e.base = d_base; e.size = d_size; e.err = err; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk_hit(input logic [39:0] a, input logic exp, input string tag);
    @(negedge clk);
    wr_en_i = 1'b0; wr_be_i = '0;
    addr_i = a;
    #1;
    checks++;
    if (hit_o !== exp) begin
      errors++;
      $display("FAIL %s: addr=%h act hit=%0b exp hit=%0b", tag, a, hit_o, exp);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    e.en = 1'b0; e.base = 40'hB000_0000; e.size = 40'h1000_0000; e.err = 1'b0; e.tag = "R1 reset";
    q.push_back(e);
    chk_hit(40'hB000_0000, 1'b0, "R1 reset no hit");

    wr(1, 8'h01, 64'h1, "R3 R9 enable 256M");
    chk_hit(40'hB123_4567, 1'b1, "R7 hit inside");
    chk_hit(40'hC000_0000, 1'b0, "R7 above window");
    chk_hit(40'hAFFF_FFFF, 1'b0, "R7 below window");

    wr(1, 8'h18, 64'h0000_0012_3C00_0000, "R2 R4 base bytes 256M mask");
    chk_hit(40'h12_3FFF_FFFF, 1'b1, "R7 top of 256M");

    wr(1, 8'h01, 64'h3, "R3 R4 128M keeps bit26");
    chk_hit(40'h12_3C00_0000, 1'b0, "R4 R7 128M base bit26 blocks hit");

    wr(1, 8'h08, 64'h0000_0000_3800_0000, "R2 single byte base");
    chk_hit(40'h12_3FFF_FFFF, 1'b1, "R7 top of 128M");
    chk_hit(40'h12_4000_0000, 1'b0, "R7 past 128M");
    chk_hit(40'h12_37FF_FFFF, 1'b0, "R7 below 128M");

    wr(1, 8'h01, 64'h5, "R3 R4 64M drops bit27");
    chk_hit(40'h12_33FF_FFFF, 1'b1, "R7 top of 64M");
    chk_hit(40'h12_3400_0000, 1'b0, "R7 past 64M");

    wr(1, 8'h01, 64'h7, "R5 reserved code rejected");
    wr(0, 8'h00, 64'h0, "R5 error pulse ends");
    wr(1, 8'h10, 64'h0000_0001_0000_0000, "R5 R6 other byte still reserved");
    chk_hit(40'h12_33FF_FFFF, 1'b1, "R5 old window kept");

    wr(1, 8'h01, 64'h0, "R2 R8 disable with new base");
    chk_hit(40'h1_3000_0000, 1'b0, "R8 disabled no hit");

    wr(0, 8'hFF, '1, "R6 wr_en low ignored");
    wr(1, 8'h00, '1, "R6 zero byte enables ignored");
    wr(1, 8'h06, '1, "R2 R6 fieldless bytes re-evaluate");

    wr(1, 8'h01, 64'h1, "R8 R9 re-enable");
    chk_hit(40'h1_3000_0000, 1'b1, "R7 base hit");
    chk_hit(40'h81_3000_0000, 1'b0, "R7 bit39 set");
    chk_hit(40'h1_2FFF_FFFF, 1'b0, "R7 just below");

    @(negedge clk);
    wr_en_i = 1'b0; wr_be_i = '0;
    @(negedge clk);
    @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: act %0d pending exp 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule